// File: doc/BRIEF.md
# Byte-Register Watchdog Timer

This block is a watchdog timer that a host controls through a small byte-wide register file: one address byte, a write-data byte with a write enable, and a read-data byte with a read enable. The host sets a timeout in whole seconds, moves the timer between an unconfigured, a stopped and a running state, and keeps it alive by writing a zero to a keep-alive register. While the timer runs, the seconds-remaining count falls once per second. When it reaches zero, the block drives a reset output for a programmable number of milliseconds. It then records the watchdog as the cause of the last reset and returns to the unconfigured state.

A prescaler, sized from a clock-frequency parameter, produces millisecond and second ticks. The prescaler restarts whenever the count is reloaded or the reset pulse begins, so each second and each pulse has an exact length. Four read-only revision bytes are parameters of the block. The serial bus that carries the register accesses is outside this block.

Top module: `regwdog`

## Requirements
- R1: After reset the state register (0x06) reads 0, the timeout (0x07) reads 30, the time-left count (0x08) reads 0, the pulse width (0x0A) reads 50, the reset-cause register (0x05) reads 0 (power cycle), and the reset output is low.
- R2: Addresses 0x01, 0x02, 0x03 and 0x04 return the firmware major, firmware minor, loader major and loader minor revision parameters. Writes to them change nothing.
- R3: A read of any address outside 0x01..0x0A, or of the keep-alive address 0x09, returns 0x00. A write to an unmapped address changes no register.
- R4: A timeout write (0x07) with a value from 3 to 255 is stored. Any other value is ignored and the old value stays.
- R5: A pulse-width write (0x0A) with a value from 1 to 255 is stored. A write of 0 is ignored.
- R6: The state encoding is 0 = unconfigured, 1 = stopped, 2 = running. A state write with a value above 2 is ignored. Writing 0 or 1 halts the countdown and freezes the time-left count.
- R7: A state write of 2 from a non-running state loads the count from the timeout. The count then falls by one every MS_PER_SEC x CLK_FREQ_HZ/1000 cycles, measured from the edge that loaded it.
- R8: While the timer runs, writing 0x00 to 0x09 reloads the count and restarts the second. A nonzero keep-alive value is ignored, and so is any keep-alive write when the timer is not running.
- R9: An accepted timeout write while the timer runs also reloads the count with the new value. When the timer is not running, the count is left alone.
- R10: On the edge where the count reaches 0, the reset output goes high for pulse-width x CLK_FREQ_HZ/1000 cycles and the reset cause becomes 1 (watchdog). During the pulse the state reads 2, and after the pulse it reads 0.
- R11: During the reset pulse, keep-alive and state writes are ignored and the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write enable, one access per cycle |
| reg_re | input | 1 | Read enable |
| reg_rdata | output | 8 | Read data, valid in the cycle reg_re is high, else 0 |
| wdt_rst_o | output | 1 | Reset pulse driven on expiry |

## Verification
The checker verifies the following on every cycle:
- the state never holds the unused code 3;
- the stored timeout and pulse width always stay inside their legal ranges;
- the count only changes by a single-step decrement unless the prescaler was just restarted;
- a running timer outside the pulse never shows a zero count;
- the reset output only appears with the running state and a zero count, and the reset cause reads watchdog when the pulse rises.

Only the bench scenarios can show the rest:
- the exact cycle in which a second elapses;
- the exact pulse length;
- that rejected writes leave the register values unchanged;
- that a keep-alive write during the pulse leaves the count at zero.

// File: rtl/regwdog_pkg.sv
package regwdog_pkg;

   localparam int unsigned REG_W = 8;

   // register addresses (the host software decodes these)
   localparam logic [REG_W-1:0] A_FW_MAJ  = 8'h01;
   localparam logic [REG_W-1:0] A_FW_MIN  = 8'h02;
   localparam logic [REG_W-1:0] A_BL_MAJ  = 8'h03;
   localparam logic [REG_W-1:0] A_BL_MIN  = 8'h04;
   localparam logic [REG_W-1:0] A_CAUSE   = 8'h05;
   localparam logic [REG_W-1:0] A_STATE   = 8'h06;
   localparam logic [REG_W-1:0] A_TMO     = 8'h07;
   localparam logic [REG_W-1:0] A_LEFT    = 8'h08;
   localparam logic [REG_W-1:0] A_KICK    = 8'h09;
   localparam logic [REG_W-1:0] A_PULSE   = 8'h0A;

   typedef enum logic [1:0] {
      ST_INIT = 2'd0,
      ST_OFF  = 2'd1,
      ST_RUN  = 2'd2
   } wd_state_e;

   // reset-cause codes; 2, 3 and 5 are unused
   localparam logic [REG_W-1:0] CAUSE_POWER   = 8'd0;
   localparam logic [REG_W-1:0] CAUSE_WDOG    = 8'd1;
   localparam logic [REG_W-1:0] CAUSE_HOST    = 8'd4;
   localparam logic [REG_W-1:0] CAUSE_BADCFG  = 8'd6;
   localparam logic [REG_W-1:0] CAUSE_BADINST = 8'd7;
   localparam logic [REG_W-1:0] CAUSE_TRAP    = 8'd8;
   localparam logic [REG_W-1:0] CAUSE_OTHER   = 8'd9;

endpackage

// File: rtl/regwdog_prescale.sv
module regwdog_prescale #(
   parameter int unsigned CLKS_PER_MS = 50000,
   parameter int unsigned MS_PER_SEC  = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic ms_tick,
   output logic sec_tick
);
   localparam int unsigned CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
   localparam int unsigned MW = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1;

   if (CLKS_PER_MS < 1) begin : g_bad_clks
      $error("CLKS_PER_MS must be at least 1");
   end
   if (MS_PER_SEC < 1) begin : g_bad_ms
      $error("MS_PER_SEC must be at least 1");
   end

   // millisecond stage
   if (CLKS_PER_MS == 1) begin : g_ms_direct
      assign ms_tick = 1'b1;
   end else begin : g_ms_div
      localparam logic [CW-1:0] CYC_LAST = CW'(CLKS_PER_MS - 1);
      logic [CW-1:0] cyc_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr)          cyc_q <= '0;
         else if (cyc_q == CYC_LAST) cyc_q <= '0;
         else                        cyc_q <= cyc_q + 1'b1;
      end
      assign ms_tick = (cyc_q == CYC_LAST);
   end

   // second stage
   if (MS_PER_SEC == 1) begin : g_sec_direct
      assign sec_tick = ms_tick;
   end else begin : g_sec_div
      localparam logic [MW-1:0] MS_LAST = MW'(MS_PER_SEC - 1);
      logic [MW-1:0] ms_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr) ms_q <= '0;
         else if (ms_tick) ms_q <= (ms_q == MS_LAST) ? '0 : ms_q + 1'b1;
      end
      assign sec_tick = ms_tick && (ms_q == MS_LAST);
   end
endmodule

// File: rtl/regwdog_core.sv
module regwdog_core
   import regwdog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             sec_tick,
   input  logic             st_wr,
   input  wd_state_e        st_val,
   input  logic             kick_wr,
   input  logic             tmo_wr,
   input  logic [REG_W-1:0] tmo_new,
   input  logic [REG_W-1:0] tmo_cur,
   input  logic [REG_W-1:0] pulse_ms,
   output wd_state_e        st_q,
   output logic [REG_W-1:0] cnt_q,
   output logic             pulse_q,
   output logic             expire,
   output logic             presc_clr
);
   logic             running, halt_wr, start, reload;
   logic [REG_W-1:0] load_val, pms_q;

   always_comb begin
      running   = (st_q == ST_RUN);
      halt_wr   = st_wr && (st_val != ST_RUN);
      start     = st_wr && (st_val == ST_RUN) && !running;
      reload    = !pulse_q && (start || (running && (kick_wr || tmo_wr)));
      load_val  = tmo_wr ? tmo_new : tmo_cur;
      expire    = running && !pulse_q && sec_tick && (cnt_q == 8'd1)
                  && !reload && !halt_wr;
      presc_clr = reload || expire;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_INIT;
         cnt_q   <= '0;
         pulse_q <= 1'b0;
         pms_q   <= '0;
      end else if (pulse_q) begin
         // host writes are locked out until the pulse ends
         if (ms_tick) begin
            if (pms_q == 8'd1) begin
               pulse_q <= 1'b0;
               st_q    <= ST_INIT;
            end
            pms_q <= pms_q - 8'd1;
         end
      end else if (expire) begin
         cnt_q   <= '0;
         pulse_q <= 1'b1;
         pms_q   <= pulse_ms;
      end else begin
         if (st_wr) st_q <= st_val;
         if (reload)
            cnt_q <= load_val;
         else if (running && sec_tick && (cnt_q != '0))
            cnt_q <= cnt_q - 8'd1;
      end
   end
endmodule

// File: rtl/regwdog.sv
module regwdog
   import regwdog_pkg::*;
#(
   parameter int unsigned CLK_FREQ_HZ = 50_000_000,
   parameter int unsigned MS_PER_SEC  = 1000,
   parameter int unsigned TMO_MIN     = 3,
   parameter int unsigned TMO_DEFAULT = 30,
   parameter int unsigned PULSE_DEF   = 50,
   parameter logic [7:0]  FW_MAJ_REV  = 8'h02,
   parameter logic [7:0]  FW_MIN_REV  = 8'h00,
   parameter logic [7:0]  BL_MAJ_REV  = 8'h01,
   parameter logic [7:0]  BL_MIN_REV  = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] reg_addr,
   input  logic [7:0] reg_wdata,
   input  logic       reg_we,
   input  logic       reg_re,
   output logic [7:0] reg_rdata,
   output logic       wdt_rst_o
);
   localparam int unsigned CLKS_PER_MS = CLK_FREQ_HZ / 1000;
   localparam logic [REG_W-1:0] TMO_MIN_B = REG_W'(TMO_MIN);
   localparam logic [REG_W-1:0] TMO_DEF_B = REG_W'(TMO_DEFAULT);
   localparam logic [REG_W-1:0] PLS_DEF_B = REG_W'(PULSE_DEF);

   if (CLK_FREQ_HZ < 1000) begin : g_bad_clk
      $error("CLK_FREQ_HZ must be at least 1000");
   end
   if (TMO_MIN < 1 || TMO_DEFAULT < TMO_MIN || TMO_DEFAULT > 255) begin : g_bad_tmo
      $error("timeout default outside its legal range");
   end
   if (PULSE_DEF < 1 || PULSE_DEF > 255) begin : g_bad_pulse
      $error("pulse default outside 1..255");
   end

   logic             ms_tick, sec_tick, presc_clr, expire;
   logic             st_wr, kick_wr, tmo_wr, dur_wr;
   wd_state_e        st_val, st_q;
   logic [REG_W-1:0] cnt_q, tmo_q, dur_q, cause_q;

   // write decode: only legal values are accepted
   always_comb begin
      st_val  = wd_state_e'(reg_wdata[1:0]);
      st_wr   = reg_we && (reg_addr == A_STATE) && (reg_wdata <= 8'd2);
      kick_wr = reg_we && (reg_addr == A_KICK)  && (reg_wdata == 8'd0);
      tmo_wr  = reg_we && (reg_addr == A_TMO)   && (reg_wdata >= TMO_MIN_B);
      dur_wr  = reg_we && (reg_addr == A_PULSE) && (reg_wdata != 8'd0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmo_q   <= TMO_DEF_B;
         dur_q   <= PLS_DEF_B;
         cause_q <= CAUSE_POWER;
      end else begin
         if (tmo_wr) tmo_q   <= reg_wdata;
         if (dur_wr) dur_q   <= reg_wdata;
         if (expire) cause_q <= CAUSE_WDOG;
      end
   end

   regwdog_prescale #(
      .CLKS_PER_MS (CLKS_PER_MS),
      .MS_PER_SEC  (MS_PER_SEC)
   ) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (presc_clr),
      .ms_tick  (ms_tick),
      .sec_tick (sec_tick)
   );

   regwdog_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .ms_tick   (ms_tick),
      .sec_tick  (sec_tick),
      .st_wr     (st_wr),
      .st_val    (st_val),
      .kick_wr   (kick_wr),
      .tmo_wr    (tmo_wr),
      .tmo_new   (reg_wdata),
      .tmo_cur   (tmo_q),
      .pulse_ms  (dur_q),
      .st_q      (st_q),
      .cnt_q     (cnt_q),
      .pulse_q   (wdt_rst_o),
      .expire    (expire),
      .presc_clr (presc_clr)
   );

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_re) begin
         case (reg_addr)
            A_FW_MAJ: reg_rdata = FW_MAJ_REV;
            A_FW_MIN: reg_rdata = FW_MIN_REV;
            A_BL_MAJ: reg_rdata = BL_MAJ_REV;
            A_BL_MIN: reg_rdata = BL_MIN_REV;
            A_CAUSE:  reg_rdata = cause_q;
            A_STATE:  reg_rdata = {6'd0, st_q};
            A_TMO:    reg_rdata = tmo_q;
            A_LEFT:   reg_rdata = cnt_q;
            A_PULSE:  reg_rdata = dur_q;
            default:  reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/regwdog_chk.sv
module regwdog_chk
   import regwdog_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       rst_o,
   input wd_state_e  st_q,
   input logic [7:0] cnt_q,
   input logic [7:0] tmo_q,
   input logic [7:0] dur_q,
   input logic [7:0] cause_q,
   input logic       presc_clr
);
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != wd_state_e'(2'd3));                                             // R6
   AST_TMO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_q >= 8'd3);                                                         // R4
   AST_PULSE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      dur_q != 8'd0);                                                         // R5
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) && !$past(presc_clr) |-> cnt_q == $past(cnt_q) - 8'd1); // R7
   AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN) && !rst_o |-> cnt_q != 8'd0);                          // R7
   AST_PULSE_CTX: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o |-> (st_q == ST_RUN) && (cnt_q == 8'd0));                         // R11
   AST_CAUSE_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_o) |-> cause_q == CAUSE_WDOG);                                // R10
endmodule

bind regwdog regwdog_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rst_o     (wdt_rst_o),
   .st_q      (st_q),
   .cnt_q     (cnt_q),
   .tmo_q     (tmo_q),
   .dur_q     (dur_q),
   .cause_q   (cause_q),
   .presc_clr (presc_clr)
);

// File: tb/regwdog_bench.sv
module regwdog_bench;
   // 4 clocks per ms, 4 ms per second: one second = 16 cycles
   localparam int SEC = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_addr = '0, reg_wdata = '0;
   logic       reg_we = 1'b0, reg_re = 1'b0;
   logic [7:0] reg_rdata;
   logic       wdt_rst_o;

   int  vectors = 0, miscompares = 0;
   bit  done = 1'b0;

   typedef struct {
      logic [7:0] exp;
      logic [7:0] addr;
      string      tag;
   } exp_t;
   exp_t sbq[$];
   exp_t cur;

   always #10 clk = ~clk;

   regwdog #(
      .CLK_FREQ_HZ (4000),
      .MS_PER_SEC  (4),
      .FW_MAJ_REV  (8'h02),
      .FW_MIN_REV  (8'h07),
      .BL_MAJ_REV  (8'h01),
      .BL_MIN_REV  (8'h04)
   ) u_regwdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_re    (reg_re),
      .reg_rdata (reg_rdata),
      .wdt_rst_o (wdt_rst_o)
   );

   // monitor: pops expected read data and compares mid-cycle
   always @(negedge clk) begin
      if (reg_re) begin
         vectors++;
         if (sbq.size() == 0) begin
            miscompares++;
            $display("FAIL scoreboard empty act=%02h exp=none", reg_rdata);
         end else begin
            cur = sbq.pop_front();
            if (reg_rdata !== cur.exp) begin
               miscompares++;
               $display("FAIL %s addr %02h act=%02h exp=%02h",
                        cur.tag, cur.addr, reg_rdata, cur.exp);
            end
         end
      end
   end

   task automatic skip(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // write lands on the second edge; returns 1 ns after it
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   // read sampled in the current cycle; returns in the next one
   task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
      exp_t it;
      it.exp = e; it.addr = a; it.tag = tag;
      sbq.push_back(it);
      reg_addr = a; reg_re = 1'b1;
      @(posedge clk); #1;
      reg_re = 1'b0;
   endtask

   task automatic chk_rst(input logic e, input string tag);
      vectors++;
      if (wdt_rst_o !== e) begin
         miscompares++;
         $display("FAIL %s reset out act=%0b exp=%0b", tag, wdt_rst_o, e);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset values
      chk_rst(1'b0, "R1");
      rd(8'h06, 8'd0,  "R1 state");
      rd(8'h07, 8'd30, "R1 timeout");
      rd(8'h08, 8'd0,  "R1 left");
      rd(8'h0A, 8'd50, "R1 pulse");
      rd(8'h05, 8'd0,  "R1 cause");
      // R2 revisions, R3 unmapped
      rd(8'h01, 8'h02, "R2 fw maj");
      rd(8'h02, 8'h07, "R2 fw min");
      rd(8'h03, 8'h01, "R2 bl maj");
      rd(8'h04, 8'h04, "R2 bl min");
      rd(8'h00, 8'h00, "R3 addr0");
      rd(8'h09, 8'h00, "R3 kick");
      rd(8'h0B, 8'h00, "R3 addr0b");
      rd(8'hFF, 8'h00, "R3 addrff");
      // R4 timeout range
      wr(8'h07, 8'd2);   rd(8'h07, 8'd30,  "R4 reject 2");
      wr(8'h07, 8'd0);   rd(8'h07, 8'd30,  "R4 reject 0");
      wr(8'h07, 8'd3);   rd(8'h07, 8'd3,   "R4 accept 3");
      wr(8'h07, 8'd255); rd(8'h07, 8'd255, "R4 accept 255");
      wr(8'h07, 8'd5);   rd(8'h07, 8'd5,   "R4 accept 5");
      // R5 pulse width
      wr(8'h0A, 8'd0);   rd(8'h0A, 8'd50, "R5 reject 0");
      wr(8'h0A, 8'd2);   rd(8'h0A, 8'd2,  "R5 accept 2");
      // R2 / R3 writes with no effect
      wr(8'h01, 8'h55);  rd(8'h01, 8'h02, "R2 ro write");
      wr(8'h20, 8'h07);
      rd(8'h07, 8'd5, "R3 tmo kept");
      rd(8'h0A, 8'd2, "R3 pulse kept");
      rd(8'h06, 8'd0, "R3 state kept");
      // R6 state encoding
      wr(8'h06, 8'd3);   rd(8'h06, 8'd0, "R6 reject 3");
      wr(8'h06, 8'd1);   rd(8'h06, 8'd1, "R6 off");
      // R8 kick while not running
      wr(8'h09, 8'd0);   rd(8'h08, 8'd0, "R8 kick idle");
      // R7 start and countdown
      wr(8'h06, 8'd2);
      rd(8'h08, 8'd5, "R7 loaded");
      skip(SEC - 2);
      rd(8'h08, 8'd5, "R7 before second");
      rd(8'h08, 8'd4, "R7 after second");
      // R8 kick reloads
      wr(8'h09, 8'd0);
      rd(8'h08, 8'd5, "R8 reload");
      skip(SEC - 2);
      rd(8'h08, 8'd5, "R8 phase restart");
      rd(8'h08, 8'd4, "R8 next second");
      wr(8'h09, 8'd7);   rd(8'h08, 8'd4, "R8 nonzero kick");
      // R6 stop freezes
      wr(8'h06, 8'd1);
      rd(8'h06, 8'd1, "R6 stopped");
      rd(8'h08, 8'd4, "R6 frozen");
      skip(40);
      rd(8'h08, 8'd4, "R6 still frozen");
      // R9 timeout write while stopped does not reload
      wr(8'h07, 8'd3);   rd(8'h08, 8'd4, "R9 no reload idle");
      // R10 expiry
      wr(8'h06, 8'd2);                 // cycle 0
      rd(8'h08, 8'd3, "R7 start 3");   // -> cycle 1
      skip(3*SEC - 2);                 // cycle 47
      chk_rst(1'b0, "R10 before expiry");
      skip(1);                         // cycle 48
      chk_rst(1'b1, "R10 pulse start");
      rd(8'h08, 8'd0, "R10 count zero");
      rd(8'h05, 8'd1, "R10 cause wdog");
      rd(8'h06, 8'd2, "R10 state in pulse");
      wr(8'h09, 8'd0);                 // R11 kick during pulse, cycle 53
      skip(2);                         // cycle 55
      chk_rst(1'b1, "R10 pulse last");
      skip(1);                         // cycle 56
      chk_rst(1'b0, "R10 pulse end");
      rd(8'h06, 8'd0, "R10 state after");
      rd(8'h08, 8'd0, "R11 count held");
      rd(8'h05, 8'd1, "R10 cause kept");
      // R9 timeout write while running reloads
      wr(8'h06, 8'd2);
      skip(20);
      rd(8'h08, 8'd2, "R9 pre");
      wr(8'h07, 8'd9);
      rd(8'h08, 8'd9, "R9 reload");
      skip(SEC - 2);
      rd(8'h08, 8'd9, "R9 before second");
      rd(8'h08, 8'd8, "R9 after second");
      wr(8'h06, 8'd1);
      skip(2);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule